// File: doc/BRIEF.md
# Receive SFD Search and Header Parser

This block sits on the receive side of a direct-sequence packet radio, after the PN acquisition stage has locked. It takes one demodulated symbol per strobe. A one-cycle `acq_start` pulse arms it. It then looks for the programmed 16-bit start frame delimiter in bit 0 of the incoming symbols. A search timer can bound this search and send the receiver back to acquisition when no delimiter turns up in time.

Once the delimiter is found, the block reads the header fields that the programmed receive mode calls for. It checks the CRC-16 over those fields and holds the received service, length and CRC values as status. In the full-header mode it takes the payload modulation from the received signal byte. It then passes payload symbols through. Optionally, it stops after the number of payload symbols given by the length field. Header errors either abort the packet or are ignored, depending on a configuration bit.

Top module: `sfd_hdr_rx`

## Requirements
- R1: After reset, `reacq`, `hdr_valid`, `pay_valid`, `pay_qpsk` and all status outputs are zero, and the block is idle until `acq_start`.
- R2: After `acq_start`, the delimiter search shift register starts cleared. Each strobe shifts in `sym_in[0]`, newest bit in the LSB. Header parsing begins on the strobe at which the register equals `cfg_sfd`. Symbols seen before `acq_start` never take part in the match.
- R3: With `cfg_sfd_tmr_en`=1, if strobe number `cfg_sfd_limit` after `acq_start` still gives no match, `reacq` pulses one cycle after that strobe and the block goes idle. A match on that same strobe wins. With the timer off, the search has no limit.
- R4: The header layout follows `cfg_mode`, each field MSB first: mode 0 has no fields; mode 1 has CRC(16); mode 2 has length(16) then CRC(16); mode 3 has signal(8), service(8), length(16) and CRC(16). `hdr_valid` pulses one cycle after the last header strobe, or after the delimiter strobe in mode 0.
- R5: The CRC uses polynomial 0x1021 with initial value 0xFFFF. It runs MSB first over the header fields between the delimiter and the CRC field, with no final inversion, and must equal the received CRC field. In mode 1 the expected value is therefore 0xFFFF.
- R6: A CRC mismatch, or a mode-3 signal byte equal to neither `cfg_code_bpsk` nor `cfg_code_qpsk`, is a header error. With `cfg_crc_abort`=1 a header error gives a `reacq` pulse instead of `hdr_valid`, and the payload symbols that follow are ignored. With `cfg_crc_abort`=0 the error is ignored.
- R7: In mode 3, `pay_qpsk` becomes 1 if the signal byte equals `cfg_code_qpsk` and 0 if it equals `cfg_code_bpsk`. In modes 0 to 2, and for an invalid signal byte under the ignore policy, `pay_qpsk` takes `cfg_preset_qpsk`. It changes only with `hdr_valid`.
- R8: `stat_service`, `stat_length` and `stat_crc` take each received field as it completes, whether or not the header is accepted. A field that is absent in the current mode keeps its old value.
- R9: After an accepted header, each strobe gives `pay_valid` one cycle later, with `pay_sym` equal to that strobe's `sym_in`.
- R10: With `cfg_len_stop`=1 in modes 2 and 3, `reacq` pulses together with the `stat_length`-th payload symbol, or with `hdr_valid` when the length is zero. Later strobes are ignored. In modes 0 and 1 the stop bit has no effect.
- R11: `acq_start` restarts the delimiter search from any state, including mid-payload.
- R12: During the search and the header, only `sym_in[0]` is used; `sym_in[1]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_start | input | 1 | Acquisition declared; starts a delimiter search |
| sym_stb | input | 1 | Symbol strobe |
| sym_in | input | SYM_W | Demodulated symbol; bit 0 carries header bits |
| cfg_mode | input | 2 | Receive header mode 0..3 |
| cfg_sfd | input | SFD_W | Delimiter value to search for |
| cfg_sfd_tmr_en | input | 1 | Enables the search timeout |
| cfg_sfd_limit | input | LIM_W | Search length in strobes |
| cfg_crc_abort | input | 1 | 1: header error aborts; 0: ignore |
| cfg_len_stop | input | 1 | Stop after the length field's symbol count |
| cfg_preset_qpsk | input | 1 | Preset payload modulation (1 = DQPSK) |
| cfg_code_bpsk | input | 8 | Signal byte meaning DBPSK payload |
| cfg_code_qpsk | input | 8 | Signal byte meaning DQPSK payload |
| reacq | output | 1 | Return-to-acquisition pulse |
| hdr_valid | output | 1 | Header accepted pulse |
| pay_valid | output | 1 | Payload symbol valid |
| pay_sym | output | SYM_W | Payload symbol |
| pay_qpsk | output | 1 | Payload modulation (1 = DQPSK) |
| stat_service | output | 8 | Last received service field |
| stat_length | output | 16 | Last received length field |
| stat_crc | output | 16 | Last received CRC field |

## Verification
Random packets vary the mode, the preamble length, the signal byte, the length, the payload count and the stop and error policies. A corrupted CRC tells the abort policy apart from the ignore policy. The three signal-byte choices (DBPSK code, DQPSK code, neither) separate the override from the preset. Payload counts above, equal to and below the length field show where the stop lands. Directed runs place the timeout exactly on, and one strobe before, the search limit. They also run a long search with the timer off and a zero length with stop enabled. Throughout, header symbols carry random upper bits.

// File: rtl/sfd_hdr_pkg.sv
package sfd_hdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HDR    = 2'd2,
        ST_PAY    = 2'd3
    } rx_state_e;

    localparam int HPOS_W   = 6;
    localparam int FLD_W    = 16;
    localparam int BYTE_W   = 8;
    // positions in the full (mode 3) layout; shorter modes start later in it
    localparam int POS_SIG_END = 7;
    localparam int POS_SVC_END = 15;
    localparam int POS_LEN_END = 31;
    localparam int POS_CRC_END = 47;
    localparam logic [FLD_W-1:0] CRC_SEED = 16'hFFFF;
    localparam logic [FLD_W-1:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sfd_hdr_crc_step.sv
module sfd_hdr_crc_step #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[W-1] ^ bit_in;
        crc_out = {crc_in[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/sfd_hdr_fieldmap.sv
module sfd_hdr_fieldmap
    import sfd_hdr_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [HPOS_W-1:0] hpos,
    output logic              crc_cover,
    output logic              sig_end,
    output logic              svc_end,
    output logic              len_end,
    output logic              crc_end
);
    logic [HPOS_W-1:0] base;
    logic [HPOS_W-1:0] vpos;

    always_comb begin
        case (mode)
            2'd3:    base = HPOS_W'(0);
            2'd2:    base = HPOS_W'(16);
            default: base = HPOS_W'(32);
        endcase
        vpos      = hpos + base;
        crc_cover = (vpos <= HPOS_W'(POS_LEN_END));
        sig_end   = (vpos == HPOS_W'(POS_SIG_END));
        svc_end   = (vpos == HPOS_W'(POS_SVC_END));
        len_end   = (vpos == HPOS_W'(POS_LEN_END));
        crc_end   = (vpos == HPOS_W'(POS_CRC_END));
    end
endmodule

// File: rtl/sfd_hdr_rx.sv
module sfd_hdr_rx
    import sfd_hdr_pkg::*;
#(
    parameter int SFD_W = 16,
    parameter int LIM_W = 10,
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_start,
    input  logic             sym_stb,
    input  logic [SYM_W-1:0] sym_in,
    input  logic [1:0]       cfg_mode,
    input  logic [SFD_W-1:0] cfg_sfd,
    input  logic             cfg_sfd_tmr_en,
    input  logic [LIM_W-1:0] cfg_sfd_limit,
    input  logic             cfg_crc_abort,
    input  logic             cfg_len_stop,
    input  logic             cfg_preset_qpsk,
    input  logic [7:0]       cfg_code_bpsk,
    input  logic [7:0]       cfg_code_qpsk,
    output logic             reacq,
    output logic             hdr_valid,
    output logic             pay_valid,
    output logic [SYM_W-1:0] pay_sym,
    output logic             pay_qpsk,
    output logic [7:0]       stat_service,
    output logic [15:0]      stat_length,
    output logic [15:0]      stat_crc
);
    typedef struct packed {
        rx_state_e         st;
        logic [SFD_W-1:0]  sfd_sr;
        logic [LIM_W-1:0]  wcnt;
        logic [HPOS_W-1:0] hpos;
        logic [FLD_W-1:0]  fsr;
        logic [FLD_W-1:0]  crc;
        logic [BYTE_W-1:0] sig;
        logic [BYTE_W-1:0] svc;
        logic [FLD_W-1:0]  len;
        logic [FLD_W-1:0]  rcrc;
        logic [FLD_W-1:0]  pcnt;
        logic              qpsk;
        logic              reacq;
        logic              hval;
        logic              pval;
        logic [SYM_W-1:0]  psym;
    } rx_regs_t;

    rx_regs_t q, d;

    logic              hb;
    logic [SFD_W-1:0]  sfd_nx;
    logic [FLD_W-1:0]  fsr_nx;
    logic [FLD_W-1:0]  crc_nx;
    logic [LIM_W:0]    wcnt_nx;
    logic [FLD_W-1:0]  pcnt_nx;
    logic              f_cover, f_sig, f_svc, f_len, f_crc;
    logic              hdr_done, crc_bad, sig_ok, hdr_err, has_len;

    assign hb = sym_in[0];

    sfd_hdr_crc_step #(.W(FLD_W), .POLY(CRC_POLY)) u_crc (
        .crc_in (q.crc),
        .bit_in (hb),
        .crc_out(crc_nx)
    );

    sfd_hdr_fieldmap u_map (
        .mode     (cfg_mode),
        .hpos     (q.hpos),
        .crc_cover(f_cover),
        .sig_end  (f_sig),
        .svc_end  (f_svc),
        .len_end  (f_len),
        .crc_end  (f_crc)
    );

    always_comb begin
        d        = q;
        d.reacq  = 1'b0;
        d.hval   = 1'b0;
        d.pval   = 1'b0;
        sfd_nx   = {q.sfd_sr[SFD_W-2:0], hb};
        fsr_nx   = {q.fsr[FLD_W-2:0], hb};
        wcnt_nx  = {1'b0, q.wcnt} + 1'b1;
        pcnt_nx  = q.pcnt + 1'b1;
        has_len  = cfg_mode[1];
        hdr_done = 1'b0;
        crc_bad  = 1'b0;
        sig_ok   = (q.sig == cfg_code_bpsk) || (q.sig == cfg_code_qpsk);

        if (acq_start) begin
            d.st     = ST_SEARCH;
            d.sfd_sr = '0;
            d.wcnt   = '0;
        end else if (sym_stb) begin
            case (q.st)
                ST_SEARCH: begin
                    d.sfd_sr = sfd_nx;
                    d.wcnt   = wcnt_nx[LIM_W-1:0];
                    if (sfd_nx == cfg_sfd) begin
                        d.hpos = '0;
                        d.crc  = CRC_SEED;
                        if (cfg_mode == 2'd0) hdr_done = 1'b1;
                        else                  d.st     = ST_HDR;
                    end else if (cfg_sfd_tmr_en && (wcnt_nx >= {1'b0, cfg_sfd_limit})) begin
                        d.st    = ST_IDLE;
                        d.reacq = 1'b1;
                    end
                end
                ST_HDR: begin
                    d.hpos = q.hpos + 1'b1;
                    d.fsr  = fsr_nx;
                    if (f_cover) d.crc = crc_nx;
                    if (f_sig)   d.sig = fsr_nx[BYTE_W-1:0];
                    if (f_svc)   d.svc = fsr_nx[BYTE_W-1:0];
                    if (f_len)   d.len = fsr_nx;
                    if (f_crc) begin
                        d.rcrc   = fsr_nx;
                        crc_bad  = (fsr_nx != q.crc);
                        hdr_done = 1'b1;
                    end
                end
                ST_PAY: begin
                    d.pval = 1'b1;
                    d.psym = sym_in;
                    d.pcnt = pcnt_nx;
                    if (cfg_len_stop && has_len && (pcnt_nx == q.len)) begin
                        d.st    = ST_IDLE;
                        d.reacq = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        hdr_err = crc_bad || ((cfg_mode == 2'd3) && !sig_ok);
        if (hdr_done) begin
            if (hdr_err && cfg_crc_abort) begin
                d.st    = ST_IDLE;
                d.reacq = 1'b1;
            end else begin
                d.hval = 1'b1;
                d.pcnt = '0;
                d.qpsk = ((cfg_mode == 2'd3) && sig_ok) ? (q.sig == cfg_code_qpsk)
                                                        : cfg_preset_qpsk;
                if (cfg_len_stop && has_len && (q.len == '0)) begin
                    d.st    = ST_IDLE;
                    d.reacq = 1'b1;
                end else begin
                    d.st = ST_PAY;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign reacq        = q.reacq;
    assign hdr_valid    = q.hval;
    assign pay_valid    = q.pval;
    assign pay_sym      = q.psym;
    assign pay_qpsk     = q.qpsk;
    assign stat_service = q.svc;
    assign stat_length  = q.len;
    assign stat_crc     = q.rcrc;
endmodule

// File: rtl/sfd_hdr_rx_chk.sv
module sfd_hdr_rx_chk #(
    parameter int SYM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_stb,
    input logic [SYM_W-1:0] sym_in,
    input logic             reacq,
    input logic             hdr_valid,
    input logic             pay_valid,
    input logic [SYM_W-1:0] pay_sym,
    input logic             pay_qpsk,
    input logic [7:0]       stat_service,
    input logic [15:0]      stat_length,
    input logic [15:0]      stat_crc
);
    assert_hdr_after_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(sym_stb));

    assert_reacq_after_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reacq |-> $past(sym_stb));

    assert_pay_follows_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> ($past(sym_stb) && ($past(sym_in) == pay_sym)));

    assert_hdr_pay_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_valid, pay_valid}));

    assert_mod_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $stable(pay_qpsk));

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sym_stb) |-> ($stable(stat_service) && $stable(stat_length) && $stable(stat_crc)));
endmodule

bind sfd_hdr_rx sfd_hdr_rx_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/sfd_hdr_rx_bench.sv
module sfd_hdr_rx_bench;
    localparam logic [15:0] SFD = 16'hF3A0;
    localparam logic [7:0]  BC  = 8'h0A;
    localparam logic [7:0]  QC  = 8'h14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acq_start = 1'b0, sym_stb = 1'b0;
    logic [1:0] sym_in = '0, cfg_mode = '0;
    logic cfg_sfd_tmr_en = 1'b0, cfg_crc_abort = 1'b0, cfg_len_stop = 1'b0, cfg_preset_qpsk = 1'b0;
    logic [9:0] cfg_sfd_limit = 10'd100;
    logic reacq, hdr_valid, pay_valid, pay_qpsk;
    logic [1:0] pay_sym;
    logic [7:0] stat_service;
    logic [15:0] stat_length, stat_crc;

    int n_chk = 0, n_fail = 0, n_hdr = 0, n_re = 0, n_pay = 0, cyc = 0;
    logic [31:0] phash = 0;
    logic [15:0] e_len = 0, e_crc = 0;
    logic [7:0]  e_svc = 0;

    always #5 clk = ~clk;

    sfd_hdr_rx u_sfd_hdr_rx (
        .clk, .rst_n, .acq_start, .sym_stb, .sym_in, .cfg_mode, .cfg_sfd(SFD),
        .cfg_sfd_tmr_en, .cfg_sfd_limit, .cfg_crc_abort, .cfg_len_stop, .cfg_preset_qpsk,
        .cfg_code_bpsk(BC), .cfg_code_qpsk(QC), .reacq, .hdr_valid, .pay_valid,
        .pay_sym, .pay_qpsk, .stat_service, .stat_length, .stat_crc
    );

    always @(posedge clk) begin
        #2;
        if (hdr_valid) n_hdr++;
        if (reacq)     n_re++;
        if (pay_valid) begin n_pay++; phash = phash * 3 + 32'(pay_sym); end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input logic [31:0] v, input int nb);
        logic [15:0] c = 16'hFFFF;
        for (int i = nb - 1; i >= 0; i--) begin
            logic fb = c[15] ^ v[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        end
        return c;
    endfunction

    task automatic stb(input logic b);
        @(negedge clk);
        sym_in  = {1'($urandom), b};   // upper bit random: R12
        sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    task automatic stb_sym(input logic [1:0] s);
        @(negedge clk);
        sym_in = s; sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    task automatic arm();
        n_hdr = 0; n_re = 0; n_pay = 0; phash = 0;
        @(negedge clk); acq_start = 1'b1;
        @(negedge clk); acq_start = 1'b0;
    endtask

    task automatic run_pkt(input int mode, input int pre, input logic [7:0] sig,
                           input logic [7:0] svc, input logic [15:0] len,
                           input bit corrupt, input int npay);
        logic [31:0] fv; int nf; logic [15:0] c;
        logic err, acc, eq; int epay, ere; logic [31:0] eh = 0;
        case (mode)
            3: begin fv = {sig, svc, len}; nf = 32; end
            2: begin fv = {16'h0, len};    nf = 16; end
            default: begin fv = 0;        nf = 0;  end
        endcase
        c = crc_of(fv, nf) ^ (corrupt ? 16'h0100 : 16'h0);
        cfg_mode = 2'(mode);
        arm();
        for (int i = 0; i < pre; i++) stb(1'b1);
        for (int i = 15; i >= 0; i--) stb(SFD[i]);
        for (int i = nf - 1; i >= 0; i--) stb(fv[i]);
        if (mode >= 1) for (int i = 15; i >= 0; i--) stb(c[i]);
        err = (mode >= 1 && corrupt) || (mode == 3 && sig != BC && sig != QC);
        acc = !(err && cfg_crc_abort);
        eq  = (mode == 3 && (sig == BC || sig == QC)) ? (sig == QC) : cfg_preset_qpsk;
        epay = 0; ere = acc ? 0 : 1;
        if (acc) begin
            if (cfg_len_stop && mode >= 2) begin
                epay = (npay < int'(len)) ? npay : int'(len);
                ere  = (npay >= int'(len)) ? 1 : 0;
            end else epay = npay;
        end
        if (mode >= 2) e_len = len;
        if (mode == 3) e_svc = svc;
        if (mode >= 1) e_crc = c;
        chk("R4/R6 header accept", 32'(n_hdr), 32'(acc));
        if (acc) chk("R7 payload modulation", 32'(pay_qpsk), 32'(eq));
        for (int i = 0; i < npay; i++) begin
            logic [1:0] s = 2'($urandom);
            stb_sym(s);
            if (i < epay) eh = eh * 3 + 32'(s);
        end
        chk("R9/R10 payload count", 32'(n_pay), 32'(epay));
        chk("R9 payload symbols", phash, eh);
        chk("R6/R10 reacq count", 32'(n_re), 32'(ere));
        chk("R8 length status", 32'(stat_length), 32'(e_len));
        chk("R8 service status", 32'(stat_service), 32'(e_svc));
        chk("R5/R8 crc status", 32'(stat_crc), 32'(e_crc));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reacq", 32'(reacq), 0);
        chk("R1 hdr_valid", 32'(hdr_valid), 0);
        chk("R1 pay_valid", 32'(pay_valid), 0);
        chk("R1 status", {stat_length, stat_crc}, 0);
        rst_n = 1'b1;
        // R1: strobes before any acq_start do nothing
        for (int i = 15; i >= 0; i--) stb(SFD[i]);
        chk("R1 idle before arm", 32'(n_hdr + n_re), 0);

        // R3 timeout exactly at limit
        cfg_mode = 2'd0; cfg_sfd_tmr_en = 1'b1; cfg_sfd_limit = 10'd10;
        arm();
        for (int i = 0; i < 9; i++) stb(1'b1);
        chk("R3 no reacq before limit", 32'(n_re), 0);
        stb(1'b1);
        chk("R3 reacq at limit", 32'(n_re), 1);
        // R3 match on the limit strobe wins
        cfg_sfd_limit = 10'd20;
        arm();
        for (int i = 0; i < 4; i++) stb(1'b1);
        for (int i = 15; i >= 0; i--) stb(SFD[i]);
        chk("R3 match at limit hdr", 32'(n_hdr), 1);
        chk("R3 match at limit reacq", 32'(n_re), 0);
        // R3 timer off: long search, R2 then still finds delimiter
        cfg_sfd_tmr_en = 1'b0;
        arm();
        for (int i = 0; i < 300; i++) stb(1'b1);
        chk("R3 timer off no reacq", 32'(n_re), 0);
        for (int i = 15; i >= 0; i--) stb(SFD[i]);
        chk("R2 delimiter found", 32'(n_hdr), 1);

        // R10 zero length with stop
        cfg_len_stop = 1'b1; cfg_crc_abort = 1'b1;
        run_pkt(2, 3, BC, 8'h00, 16'd0, 1'b0, 3);
        // R6 corrupted crc both policies, R11 restart mid-payload
        run_pkt(1, 2, BC, 8'h00, 16'd0, 1'b1, 2);
        cfg_crc_abort = 1'b0; cfg_len_stop = 1'b0;
        run_pkt(3, 5, QC, 8'h5A, 16'd4, 1'b1, 5);
        cfg_preset_qpsk = 1'b1;
        run_pkt(3, 1, 8'hEE, 8'h33, 16'd2, 1'b0, 2);  // R7 invalid signal, preset used

        // random packets
        for (int k = 0; k < 60; k++) begin
            int m = int'($urandom % 4);
            int pr = int'($urandom % 24);
            int sel = int'($urandom % 4);
            logic [7:0] sg = (sel < 2) ? BC : (sel == 2 ? QC : 8'($urandom));
            cfg_crc_abort   = 1'($urandom);
            cfg_len_stop    = 1'($urandom);
            cfg_preset_qpsk = 1'($urandom);
            cfg_sfd_tmr_en  = 1'($urandom);
            cfg_sfd_limit   = 10'(pr + 16 + int'($urandom % 5));
            run_pkt(m, pr, sg, 8'($urandom), 16'($urandom % 12),
                    ($urandom % 4) == 0, int'($urandom % 11));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule